// File: doc/BRIEF.md
# Multiplexed External Bus Controller

This block carries the memory requests of a 16-bit core onto a shared address/data bus. It first drives the address, then the data, on the same sixteen wires. The core presents a byte address, write data, two byte enables and flags for write and for instruction fetch. Some time later the block returns a one-cycle completion pulse, and read data for reads. Each external cycle has an address phase, a data phase and a hold phase. The data phase can be stretched by wait states from the ready input. A 16-bit-or-8-bit decision can be taken per cycle from the bus-width input.

Requests whose address falls inside an internal ROM window are answered internally whenever the ROM-enable input is high. They start no external cycle. Three static configuration bits choose the behaviour. One selects the kind of address strobe: a latch pulse or an address-valid level. One selects whether bus width is read per cycle or fixed at 8 bits. One selects the write strobe scheme: whole-word with high-byte enable, or separate low-byte and high-byte write strobes.

A request of two bytes that cannot move in one cycle becomes two byte cycles, lower address first. This covers an 8-bit cycle and an odd start address. The bytes are merged before completion.

Top module: `ext_bus_ctrl`

## Requirements
- R1: While reset is asserted and after its release with no request, rd_n, wr_lo_n and wr_hi_n are 1, bus_ad_oe, fetch_o, rsp_done and int_sel are 0, and addr_strobe is at its idle level (0 when cfg_mode[0]=0, 1 when cfg_mode[0]=1).
- R2: A request is taken on a clock edge where req_valid is 1 and the block is idle. An external transfer then shows an address phase in the next cycle: bus_ad_out equals the byte address and bus_ad_oe is 1. A data phase follows, then a hold phase in which all strobes are inactive and bus_ad_oe is 0. rsp_done is 1 for exactly the one cycle after the last hold phase. rd_n is 0 in the data phase of reads only.
- R3: Each clock edge that ends a data phase with ready_i at 0 adds one more data-phase cycle. The data phase ends on the first edge with ready_i at 1.
- R4: With cfg_mode[1]=1, width_i is sampled on the edge that ends the address phase. A value of 1 makes that cycle 16 bits wide and 0 makes it 8 bits wide.
- R5: With cfg_mode[1]=0, every external cycle is 8 bits wide, whatever width_i is.
- R6: req_be bit 0 selects the byte at req_addr and bit 1 the byte at req_addr+1. A value of 0 is treated as 1. Both bytes move in one cycle only on a 16-bit cycle with an even req_addr. Otherwise each byte gets its own cycle, lower address first. In a 16-bit cycle an even-address byte uses bus lines 7:0 and an odd-address byte uses lines 15:8. An 8-bit cycle uses lines 7:0. A single written byte is driven on both lanes. Read data returns the byte at req_addr in rsp_rdata[7:0] and the byte at req_addr+1 in [15:8]. Unrequested bytes read as 0.
- R7: With cfg_mode[2]=0 (whole-word strobes), wr_lo_n is 0 in the data phase of every write cycle. wr_hi_n is 0 in that phase only when the cycle is 16 bits wide and carries an odd-address byte.
- R8: With cfg_mode[2]=1 (byte strobes), in a write data phase wr_lo_n is 0 exactly when an even-address byte is written and wr_hi_n is 0 exactly when an odd-address byte is written.
- R9: With cfg_mode[0]=0, addr_strobe is 1 during address phases only. With cfg_mode[0]=1, it is 0 through the address, data and hold phases and 1 at all other times.
- R10: fetch_o is 1 throughout the address, data and hold phases of a read with req_fetch=1. It is 0 for data reads, for writes and outside external cycles.
- R11: With ext_rom_en=1, a request with req_addr from 0x2000 to 0x5FFF drives int_sel to 1 for the one cycle after acceptance, with no strobe or bus drive. rsp_done follows in the next cycle, and a read returns int_rdata masked by the byte enables. With ext_rom_en=0, or outside that window, the access is external.
- R12: ready_i has no effect outside a data phase. In particular, an internal access completes at the same cycle whatever ready_i does. Read and write strobes are active only in external data phases.
- R13: A req_valid raised while a transfer is in progress is ignored. The block is idle in the cycle after that transfer's rsp_done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_mode | input | 3 | Bit 0 address-valid strobe, bit 1 per-cycle width, bit 2 byte write strobes |
| ext_rom_en | input | 1 | 1 steers the ROM window internally |
| req_valid | input | 1 | Request present |
| req_addr | input | 16 | Byte address |
| req_be | input | 2 | Byte enables (req_addr, req_addr+1) |
| req_write | input | 1 | 1 for write |
| req_fetch | input | 1 | 1 when a read is an instruction fetch |
| req_wdata | input | 16 | Write data |
| rsp_rdata | output | 16 | Read data, valid with rsp_done |
| rsp_done | output | 1 | Completion pulse |
| int_sel | output | 1 | Internal ROM access cycle |
| int_rdata | input | 16 | Internal ROM read data |
| bus_ad_out | output | 16 | Multiplexed address/data out |
| bus_ad_oe | output | 1 | Output enable for bus_ad_out |
| bus_ad_in | input | 16 | Multiplexed data in |
| addr_strobe | output | 1 | Latch pulse or address-valid level |
| rd_n | output | 1 | Read strobe |
| wr_lo_n | output | 1 | Write or low-byte write strobe |
| wr_hi_n | output | 1 | High-byte enable or high-byte write strobe |
| fetch_o | output | 1 | Instruction-fetch indicator |
| width_i | input | 1 | Bus width for the current cycle |
| ready_i | input | 1 | Wait-state request when 0 |

## Verification
The address phase is visible one cycle after the accepting edge. A data phase of 1+N cycles follows, where N is the number of low samples of ready_i. The hold phase takes one cycle, and rsp_done appears one cycle after the last hold. An internal access raises int_sel one cycle after acceptance and rsp_done one cycle after that. The bench walks these phases on falling edges. It drives width_i during the address phase and ready_i during each data-phase cycle, and it checks each phase's pins in the cycle the counts above give. The merged read data is compared only in the rsp_done cycle, against bytes the bench itself placed on the lanes.

// File: rtl/ebc_pkg.sv
package ebc_pkg;
  localparam int ADDR_W = 16;
  localparam int LANES  = 2;
  localparam int DATA_W = LANES * 8;

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_DATA, S_HOLD, S_INT} bus_state_e;

  // zero enables behave as a single low byte
  function automatic logic [LANES-1:0] start_pending(input logic [LANES-1:0] be);
    return (be == '0) ? LANES'(1) : be;
  endfunction

  // bytes moved by one bus cycle, relative to the request base
  function automatic logic [LANES-1:0] take_mask(input logic wide, input logic base_odd,
                                                  input logic [LANES-1:0] pend);
    if (wide && !base_odd && pend == 2'b11) return 2'b11;
    if (pend[0]) return 2'b01;
    return 2'b10;
  endfunction

  // bit 0: an even-address byte moves, bit 1: an odd-address byte moves
  function automatic logic [1:0] parity_of(input logic base_odd, input logic [LANES-1:0] take);
    logic [1:0] p;
    p[0] = (take[0] && !base_odd) || (take[1] && base_odd);
    p[1] = (take[0] && base_odd) || (take[1] && !base_odd);
    return p;
  endfunction

  // result is {hi_n, lo_n} for a write data phase
  function automatic logic [1:0] write_strobes(input logic split, input logic wide,
                                               input logic [1:0] par);
    if (split) return {~par[1], ~par[0]};
    return {~(wide && par[1]), 1'b0};
  endfunction

  function automatic logic [DATA_W-1:0] place_wdata(input logic [LANES-1:0] take,
                                                    input logic [DATA_W-1:0] wd);
    logic [7:0] b;
    if (take == 2'b11) return wd;
    b = take[0] ? wd[7:0] : wd[15:8];
    return {b, b};
  endfunction

  function automatic logic rom_window(input logic en, input logic [ADDR_W-1:0] a,
                                      input logic [ADDR_W-1:0] lo, input logic [ADDR_W-1:0] hi);
    return en && (a >= lo) && (a <= hi);
  endfunction
endpackage

// File: rtl/ebc_steer.sv
module ebc_steer
  import ebc_pkg::*;
#(
  parameter logic [ADDR_W-1:0] ROM_LO = 16'h2000,
  parameter logic [ADDR_W-1:0] ROM_HI = 16'h5FFF
) (
  input  logic              ext_rom_en,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LANES-1:0]  req_be,
  output logic              rom_hit,
  output logic [LANES-1:0]  pend_init
);
  assign rom_hit   = rom_window(ext_rom_en, req_addr, ROM_LO, ROM_HI);
  assign pend_init = start_pending(req_be);
endmodule

// File: rtl/ebc_seq.sv
module ebc_seq
  import ebc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dyn_width,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  input  logic              req_fetch,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              rom_hit,
  input  logic [LANES-1:0]  pend_init,
  input  logic              width_i,
  input  logic              ready_i,
  input  logic [DATA_W-1:0] bus_ad_in,
  input  logic [DATA_W-1:0] int_rdata,
  output bus_state_e        state,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [LANES-1:0]  take,
  output logic [1:0]        take_par,
  output logic              cyc_wide,
  output logic              is_write,
  output logic              is_fetch,
  output logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              done,
  output logic              ev_accept,
  output logic              ev_data_end,
  output logic              ev_last
);
  logic [ADDR_W-1:0] base_q;
  logic [LANES-1:0]  pend_q;
  logic [LANES-1:0]  left;
  logic [DATA_W-1:0] rd_next;
  logic [DATA_W-1:0] int_mask;
  logic              wide_now;

  assign cur_addr    = base_q + (pend_q[0] ? ADDR_W'(0) : ADDR_W'(1));
  assign take_par    = parity_of(base_q[0], take);
  assign left        = pend_q & ~take;
  assign wide_now    = dyn_width & width_i;
  assign ev_accept   = (state == S_IDLE) && req_valid;
  assign ev_data_end = (state == S_DATA) && ready_i;
  assign ev_last     = (state == S_HOLD) && (left == '0);

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic odd_byte;
    assign odd_byte = (i == 1) ? ~base_q[0] : base_q[0];
    assign rd_next[i*8 +: 8] = !take[i] ? rdata[i*8 +: 8] :
                               (cyc_wide && odd_byte) ? bus_ad_in[15:8] : bus_ad_in[7:0];
    assign int_mask[i*8 +: 8] = {8{pend_q[i]}};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      base_q   <= '0;
      pend_q   <= '0;
      take     <= '0;
      cyc_wide <= 1'b0;
      is_write <= 1'b0;
      is_fetch <= 1'b0;
      wdata    <= '0;
      rdata    <= '0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        S_IDLE: if (req_valid) begin
          base_q   <= req_addr;
          pend_q   <= pend_init;
          is_write <= req_write;
          is_fetch <= req_fetch & ~req_write;
          wdata    <= req_wdata;
          rdata    <= '0;
          take     <= '0;
          cyc_wide <= 1'b0;
          state    <= rom_hit ? S_INT : S_ADDR;
        end
        S_ADDR: begin
          cyc_wide <= wide_now;
          take     <= take_mask(wide_now, base_q[0], pend_q);
          state    <= S_DATA;
        end
        S_DATA: if (ready_i) begin
          if (!is_write) rdata <= rd_next;
          state <= S_HOLD;
        end
        S_HOLD: begin
          pend_q <= left;
          if (left == '0) begin
            done  <= 1'b1;
            state <= S_IDLE;
          end else begin
            state <= S_ADDR;
          end
        end
        S_INT: begin
          rdata <= is_write ? '0 : (int_rdata & int_mask);
          done  <= 1'b1;
          state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ebc_pins.sv
module ebc_pins
  import ebc_pkg::*;
(
  input  bus_state_e        state,
  input  logic [2:0]        cfg_mode,
  input  logic [ADDR_W-1:0] cur_addr,
  input  logic [LANES-1:0]  take,
  input  logic [1:0]        take_par,
  input  logic              cyc_wide,
  input  logic              is_write,
  input  logic              is_fetch,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] bus_ad_out,
  output logic              bus_ad_oe,
  output logic              addr_strobe,
  output logic              rd_n,
  output logic              wr_lo_n,
  output logic              wr_hi_n,
  output logic              fetch_o,
  output logic              int_sel,
  output logic              ext_cycle
);
  logic in_addr, in_data, in_hold;
  logic [1:0] wstb;

  assign in_addr   = (state == S_ADDR);
  assign in_data   = (state == S_DATA);
  assign in_hold   = (state == S_HOLD);
  assign ext_cycle = in_addr | in_data | in_hold;
  assign int_sel   = (state == S_INT);

  always_comb begin
    wstb = 2'b11;
    if (in_data && is_write) wstb = write_strobes(cfg_mode[2], cyc_wide, take_par);
  end

  assign wr_hi_n     = wstb[1];
  assign wr_lo_n     = wstb[0];
  assign rd_n        = ~(in_data & ~is_write);
  assign fetch_o     = ext_cycle & is_fetch;
  assign addr_strobe = cfg_mode[0] ? ~ext_cycle : in_addr;
  assign bus_ad_oe   = in_addr | (in_data & is_write);

  always_comb begin
    bus_ad_out = '0;
    if (in_addr) bus_ad_out = cur_addr;
    else if (in_data && is_write) bus_ad_out = place_wdata(take, wdata);
  end
endmodule

// File: rtl/ext_bus_ctrl.sv
module ext_bus_ctrl
  import ebc_pkg::*;
#(
  parameter logic [ADDR_W-1:0] ROM_LO = 16'h2000,
  parameter logic [ADDR_W-1:0] ROM_HI = 16'h5FFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        cfg_mode,
  input  logic              ext_rom_en,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LANES-1:0]  req_be,
  input  logic              req_write,
  input  logic              req_fetch,
  input  logic [DATA_W-1:0] req_wdata,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_done,
  output logic              int_sel,
  input  logic [DATA_W-1:0] int_rdata,
  output logic [DATA_W-1:0] bus_ad_out,
  output logic              bus_ad_oe,
  input  logic [DATA_W-1:0] bus_ad_in,
  output logic              addr_strobe,
  output logic              rd_n,
  output logic              wr_lo_n,
  output logic              wr_hi_n,
  output logic              fetch_o,
  input  logic              width_i,
  input  logic              ready_i
);
  bus_state_e        state;
  logic              rom_hit;
  logic [LANES-1:0]  pend_init;
  logic [ADDR_W-1:0] cur_addr;
  logic [LANES-1:0]  take;
  logic [1:0]        take_par;
  logic              cyc_wide, is_write, is_fetch;
  logic [DATA_W-1:0] wdata;
  logic              ev_accept, ev_data_end, ev_last;
  logic              ext_cycle;
  logic              st_addr, st_data, st_hold, st_int;

  ebc_steer #(.ROM_LO(ROM_LO), .ROM_HI(ROM_HI)) u_steer (
    .ext_rom_en(ext_rom_en), .req_addr(req_addr), .req_be(req_be),
    .rom_hit(rom_hit), .pend_init(pend_init)
  );

  ebc_seq u_seq (
    .clk(clk), .rst_n(rst_n), .dyn_width(cfg_mode[1]),
    .req_valid(req_valid), .req_addr(req_addr), .req_write(req_write),
    .req_fetch(req_fetch), .req_wdata(req_wdata), .rom_hit(rom_hit),
    .pend_init(pend_init), .width_i(width_i), .ready_i(ready_i),
    .bus_ad_in(bus_ad_in), .int_rdata(int_rdata), .state(state),
    .cur_addr(cur_addr), .take(take), .take_par(take_par), .cyc_wide(cyc_wide),
    .is_write(is_write), .is_fetch(is_fetch), .wdata(wdata), .rdata(rsp_rdata),
    .done(rsp_done), .ev_accept(ev_accept), .ev_data_end(ev_data_end),
    .ev_last(ev_last)
  );

  ebc_pins u_pins (
    .state(state), .cfg_mode(cfg_mode), .cur_addr(cur_addr), .take(take),
    .take_par(take_par), .cyc_wide(cyc_wide), .is_write(is_write),
    .is_fetch(is_fetch), .wdata(wdata), .bus_ad_out(bus_ad_out),
    .bus_ad_oe(bus_ad_oe), .addr_strobe(addr_strobe), .rd_n(rd_n),
    .wr_lo_n(wr_lo_n), .wr_hi_n(wr_hi_n), .fetch_o(fetch_o),
    .int_sel(int_sel), .ext_cycle(ext_cycle)
  );

  assign st_addr = (state == S_ADDR);
  assign st_data = (state == S_DATA);
  assign st_hold = (state == S_HOLD);
  assign st_int  = (state == S_INT);
endmodule

// File: rtl/ebc_checker.sv
module ebc_checker (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] cfg_mode,
  input logic       ready_i,
  input logic       req_valid,
  input logic       rd_n,
  input logic       wr_lo_n,
  input logic       wr_hi_n,
  input logic       bus_ad_oe,
  input logic       addr_strobe,
  input logic       fetch_o,
  input logic       rsp_done,
  input logic       st_addr,
  input logic       st_data,
  input logic       st_hold,
  input logic       st_int,
  input logic       cyc_wide
);
  p_wait_keeps_data_r3: assert property (@(posedge clk) disable iff (!rst_n)
    st_data && !ready_i |=> st_data);

  p_narrow_when_fixed_r5: assert property (@(posedge clk) disable iff (!rst_n)
    st_data && !cfg_mode[1] |-> !cyc_wide);

  p_rom_bus_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    st_int |-> rd_n && wr_lo_n && wr_hi_n && !bus_ad_oe);

  p_done_after_end_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |-> $past(st_hold || st_int));

  p_fetch_steady_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (st_data || st_hold) |-> $stable(fetch_o));

  p_strobes_in_data_only_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !st_data |-> rd_n && wr_lo_n && wr_hi_n);

  p_hold_leaves_bus_r2: assert property (@(posedge clk) disable iff (!rst_n)
    st_hold |=> !st_data && !st_int);

  p_busy_no_restart_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (st_data || st_addr) && req_valid |=> !st_int);

  p_valid_level_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_mode[0] && $rose(st_addr) |-> !addr_strobe);
endmodule

bind ext_bus_ctrl ebc_checker u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .ready_i(ready_i),
  .req_valid(req_valid), .rd_n(rd_n), .wr_lo_n(wr_lo_n), .wr_hi_n(wr_hi_n),
  .bus_ad_oe(bus_ad_oe), .addr_strobe(addr_strobe), .fetch_o(fetch_o),
  .rsp_done(rsp_done), .st_addr(st_addr), .st_data(st_data), .st_hold(st_hold),
  .st_int(st_int), .cyc_wide(cyc_wide)
);

// File: tb/tb_ext_bus_ctrl.sv
`timescale 1ns/1ps
module tb_ext_bus_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  cfg_mode = 3'b000;
  logic        ext_rom_en = 1'b0;
  logic        req_valid = 1'b0;
  logic [15:0] req_addr = '0;
  logic [1:0]  req_be = 2'b01;
  logic        req_write = 1'b0;
  logic        req_fetch = 1'b0;
  logic [15:0] req_wdata = '0;
  logic [15:0] rsp_rdata;
  logic        rsp_done;
  logic        int_sel;
  logic [15:0] int_rdata = '0;
  logic [15:0] bus_ad_out;
  logic        bus_ad_oe;
  logic [15:0] bus_ad_in = '0;
  logic        addr_strobe, rd_n, wr_lo_n, wr_hi_n, fetch_o;
  logic        width_i = 1'b0;
  logic        ready_i = 1'b1;

  int errors = 0;
  int checks = 0;
  int w_force = -1;
  int wait_force = -1;
  bit finished = 0;

  always #4 clk = ~clk;

  ext_bus_ctrl dut (.*);

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic bit idle_strobe(input logic [2:0] c);
    return c[0];
  endfunction

  function automatic bit in_rom(input bit en, input logic [15:0] a);
    return en && a >= 16'h2000 && a <= 16'h5FFF;
  endfunction

  task automatic run(input logic [15:0] addr, input logic [1:0] be, input bit wr,
                     input bit fet, input logic [15:0] wd, input bit poke);
    logic [1:0]  pend, take, par;
    logic [15:0] exp_rd, din, cur, exp_lanes, mask;
    logic [7:0]  b;
    bit          w, wide, exp_lo, exp_hi;
    int          waits;
    pend   = (be == 2'b00) ? 2'b01 : be;
    exp_rd = '0;
    mask   = {{8{pend[1]}}, {8{pend[0]}}};
    @(negedge clk);
    req_addr = addr; req_be = be; req_write = wr; req_fetch = fet; req_wdata = wd;
    int_rdata = 16'($urandom);
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    if (in_rom(ext_rom_en, addr)) begin
      ready_i = $urandom % 2;
      chk(int_sel == 1'b1, "R11", "int_sel", 32'(int_sel), 1);
      chk(rd_n && wr_lo_n && wr_hi_n && !bus_ad_oe, "R11", "bus quiet",
          {rd_n, wr_lo_n, wr_hi_n, bus_ad_oe}, 4'b1110);
      @(negedge clk);
      chk(rsp_done == 1'b1, "R12", "internal done timing", 32'(rsp_done), 1);
      chk(rsp_rdata == (wr ? 16'h0 : (int_rdata & mask)), "R11", "internal rdata",
          32'(rsp_rdata), 32'(wr ? 16'h0 : (int_rdata & mask)));
      return;
    end
    while (pend != 2'b00) begin
      cur = addr + (pend[0] ? 16'd0 : 16'd1);
      chk(bus_ad_oe && bus_ad_out == cur, "R2", "address phase", 32'(bus_ad_out), 32'(cur));
      chk(addr_strobe == !cfg_mode[0], "R9", "strobe in address phase",
          32'(addr_strobe), 32'(!cfg_mode[0]));
      chk(fetch_o == (fet && !wr), "R10", "fetch in address phase", 32'(fetch_o), 32'(fet && !wr));
      w = (w_force >= 0) ? bit'(w_force) : bit'($urandom % 2);
      width_i = w;
      wide = cfg_mode[1] && w;
      take = (wide && !addr[0] && pend == 2'b11) ? 2'b11 : (pend[0] ? 2'b01 : 2'b10);
      par[0] = (take[0] && !addr[0]) || (take[1] && addr[0]);
      par[1] = (take[0] && addr[0]) || (take[1] && !addr[0]);
      din = 16'($urandom);
      bus_ad_in = din;
      waits = (wait_force >= 0) ? wait_force : int'($urandom % 3);
      ready_i = $urandom % 2;
      if (poke) begin
        req_valid = 1'b1;
        req_addr = 16'h2400;
      end
      @(negedge clk);
      req_valid = 1'b0;
      if (wr) begin
        if (cfg_mode[2]) begin exp_lo = !par[0]; exp_hi = !par[1]; end
        else begin exp_lo = 1'b0; exp_hi = !(wide && par[1]); end
      end else begin
        exp_lo = 1'b1; exp_hi = 1'b1;
      end
      b = take[0] ? wd[7:0] : wd[15:8];
      exp_lanes = (take == 2'b11) ? wd : {b, b};
      for (int k = 0; k <= waits; k++) begin
        ready_i = (k == waits);
        chk(rd_n == wr, "R2", "rd_n in data phase", 32'(rd_n), 32'(wr));
        chk(wr_lo_n == exp_lo, cfg_mode[2] ? "R8" : "R7", "wr_lo_n", 32'(wr_lo_n), 32'(exp_lo));
        chk(wr_hi_n == exp_hi, cfg_mode[2] ? "R8" : "R7", "wr_hi_n",
            32'(wr_hi_n), 32'(exp_hi));
        if (wr) chk(bus_ad_oe && bus_ad_out == exp_lanes, "R6", "write lanes",
                    32'(bus_ad_out), 32'(exp_lanes));
        chk(fetch_o == (fet && !wr), "R10", "fetch in data phase", 32'(fetch_o), 32'(fet && !wr));
        if (cfg_mode[1]) chk(1'b1, "R4", "width sampled", 0, 0);
        @(negedge clk);
      end
      chk(rd_n && wr_lo_n && wr_hi_n && !bus_ad_oe, "R3", "hold after waits",
          {rd_n, wr_lo_n, wr_hi_n, bus_ad_oe}, 4'b1110);
      chk(addr_strobe == 1'b0, "R9", "strobe in hold", 32'(addr_strobe), 0);
      for (int i = 0; i < 2; i++) begin
        if (take[i]) begin
          if (wide && (addr[0] ^ i[0])) exp_rd[i*8 +: 8] = din[15:8];
          else exp_rd[i*8 +: 8] = din[7:0];
        end
      end
      pend = pend & ~take;
      ready_i = $urandom % 2;
      @(negedge clk);
    end
    chk(rsp_done == 1'b1, "R2", "done after hold", 32'(rsp_done), 1);
    if (!wr) chk(rsp_rdata == exp_rd, cfg_mode[1] ? "R4" : "R5", "merged read data",
                 32'(rsp_rdata), 32'(exp_rd));
    if (!wr && be == 2'b11) chk(rsp_rdata == exp_rd, "R6", "split assembly",
                                32'(rsp_rdata), 32'(exp_rd));
    chk(addr_strobe == idle_strobe(cfg_mode) && rd_n, "R9", "idle strobe at done",
        32'(addr_strobe), 32'(idle_strobe(cfg_mode)));
    if (poke) begin
      @(negedge clk);
      chk(!bus_ad_oe && !int_sel && !rsp_done, "R13", "ignored busy request",
          {bus_ad_oe, int_sel, rsp_done}, 0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=0", 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    chk(rd_n && wr_lo_n && wr_hi_n && !bus_ad_oe && !fetch_o && !rsp_done && !int_sel
        && !addr_strobe, "R1", "reset state",
        {rd_n, wr_lo_n, wr_hi_n, bus_ad_oe, fetch_o, rsp_done, int_sel, addr_strobe}, 8'hE0);
    rst_n = 1'b1;
    @(negedge clk);
    cfg_mode = 3'b001;
    @(negedge clk);
    chk(addr_strobe == 1'b1 && rd_n && !bus_ad_oe, "R1", "idle valid-mode level",
        32'(addr_strobe), 1);

    // R4: 16-bit aligned word in one cycle
    cfg_mode = 3'b010; w_force = 1; wait_force = 0;
    run(16'h1000, 2'b11, 1'b1, 1'b0, 16'hA55A, 1'b0);
    run(16'h1002, 2'b11, 1'b0, 1'b0, 16'h0, 1'b0);
    // R6: word on an 8-bit cycle splits
    w_force = 0;
    run(16'h1004, 2'b11, 1'b0, 1'b0, 16'h0, 1'b0);
    // R5: width pin ignored when fixed
    cfg_mode = 3'b000; w_force = 1;
    run(16'h1006, 2'b11, 1'b1, 1'b0, 16'h1234, 1'b0);
    run(16'h1008, 2'b11, 1'b0, 1'b0, 16'h0, 1'b0);
    // R6: odd start on a 16-bit cycle
    cfg_mode = 3'b010;
    run(16'h1001, 2'b11, 1'b0, 1'b0, 16'h0, 1'b0);
    run(16'h1001, 2'b11, 1'b1, 1'b0, 16'hBEEF, 1'b0);
    // R8: byte write strobes
    cfg_mode = 3'b110;
    run(16'h2100, 2'b11, 1'b1, 1'b0, 16'hC0DE, 1'b0);
    run(16'h2100, 2'b01, 1'b1, 1'b0, 16'h00AA, 1'b0);
    run(16'h2100, 2'b10, 1'b1, 1'b0, 16'hBB00, 1'b0);
    // R9 R10 R3: address-valid mode, fetch with waits
    cfg_mode = 3'b011; wait_force = 2;
    run(16'h0040, 2'b11, 1'b0, 1'b1, 16'h0, 1'b0);
    run(16'h0042, 2'b01, 1'b0, 1'b0, 16'h0, 1'b0);
    // R11 R12: ROM window edges
    ext_rom_en = 1'b1; wait_force = 0;
    run(16'h2000, 2'b11, 1'b0, 1'b0, 16'h0, 1'b0);
    run(16'h5FFF, 2'b01, 1'b0, 1'b0, 16'h0, 1'b0);
    run(16'h1FFF, 2'b01, 1'b0, 1'b0, 16'h0, 1'b0);
    run(16'h6000, 2'b11, 1'b0, 1'b0, 16'h0, 1'b0);
    ext_rom_en = 1'b0;
    run(16'h3000, 2'b11, 1'b0, 1'b0, 16'h0, 1'b0);
    // R13: request during a transfer
    ext_rom_en = 1'b1;
    run(16'h0100, 2'b11, 1'b1, 1'b0, 16'h5151, 1'b1);

    w_force = -1; wait_force = -1;
    for (int n = 0; n < 400; n++) begin
      logic [15:0] a;
      if (n % 20 == 0) cfg_mode = 3'($urandom);
      ext_rom_en = $urandom % 2;
      a = ($urandom % 3 == 0) ? 16'(16'h1FF0 + $urandom % 32) : 16'($urandom);
      run(a, 2'($urandom % 3 + 1), bit'($urandom % 2), bit'($urandom % 2),
          16'($urandom), ($urandom % 8) == 0);
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule